// File: doc/BRIEF.md
# Short-Instruction Effective Address Generator

This block resolves the address part of a 12-bit one-address instruction. The word splits into a 6-bit function code in the upper half and a 6-bit offset field in the lower half. When the block accepts an instruction, it latches the function code and holds it until the next instruction is accepted. It then produces one 12-bit value. Depending on a 2-bit mode input, that value is an immediate constant, a low-memory address, a pointer-chased address, or an address relative to the program counter. A one-cycle `done` strobe marks the value.

The block also owns the program counter. The counter steps by one for every accepted instruction. For a jump, the computed value is loaded into the counter instead. The indirect mode needs one word from memory, which it reads over a simple request/acknowledge port. The memory may take any number of cycles to answer, and the block stays busy until it does. Each memory reference first puts its address into an internal storage address register, which drives the memory address port directly.

Top module: `short_ea_unit`

## Requirements
- R1: After reset, `pc` is 0 and `done`, `busy` and `mem_req` are all low.
- R2: An instruction is accepted when `start` is high and `busy` is low. From the cycle after acceptance, `func_code` shows `instr[11:6]`, and it stays unchanged until the next accepted instruction.
- R3: An accepted instruction with `is_jump` low leaves `pc` one higher, modulo 4096, the cycle after acceptance.
- R4: With `mode` = 00 (immediate), `done` rises the cycle after acceptance. `result` is `instr[5:0]` with six zero bits above it, and `result_imm` is high.
- R5: With `mode` = 01 (low-memory direct), `done` rises the cycle after acceptance. `result` and `mem_addr` both equal the zero-extended offset, and `result_imm` is low.
- R6: With `mode` = 11 and `rel_back` low, `result` is the pre-increment `pc` plus the offset, modulo 4096, with `done` the cycle after acceptance.
- R7: With `mode` = 11 and `rel_back` high, `result` is the pre-increment `pc` minus the offset, modulo 4096.
- R8: With `mode` = 10 and `is_jump` low, `mem_req` is high from the cycle after acceptance until the cycle `mem_ack` is sampled high. During that time `mem_addr` is the zero-extended offset. `done` follows one cycle after the acknowledge, with `result` equal to the `mem_rdata` sampled with it.
- R9: With `mode` = 10 and `is_jump` high, the pointer is the pre-increment `pc` plus the offset, regardless of `rel_back`. The word read there appears on `result` and is loaded into `pc` in the same cycle that `done` rises.
- R10: For an accepted jump in modes 00, 01 or 11, `pc` takes the value of `result` instead of stepping by one.
- R11: A `start` pulse while `busy` is high has no effect: it causes no extra `done`, and it leaves `pc` and `func_code` unchanged.
- R12: `mem_req` is high only while `busy` is high, and never in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offer an instruction this cycle |
| instr | input | 12 | Instruction word: function code above, offset below |
| mode | input | 2 | 00 immediate, 01 direct, 10 indirect, 11 relative |
| rel_back | input | 1 | Relative mode subtracts the offset when high |
| is_jump | input | 1 | Result is a jump target to load into `pc` |
| mem_req | output | 1 | Indirect word read pending |
| mem_addr | output | 12 | Storage address register |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 12 | Read data |
| busy | output | 1 | Waiting for an indirect read; new starts are ignored |
| done | output | 1 | One-cycle strobe: `result` is valid |
| result | output | 12 | Effective address or immediate operand |
| result_imm | output | 1 | `result` is an immediate operand |
| func_code | output | 6 | Function code of the accepted instruction |
| pc | output | 12 | Program counter |

## Verification
The main function is driven through a sequence in which each result feeds the program counter used by the next instruction. Because of this, a wrong carry, direction or pointer source also shifts every later expected value. Subtracting an offset from a counter of 2 tells correct wrap-around below zero apart from a saturating or unsigned fault. Adding 63 to a counter near the top tells correct modulo wrap apart from overflow. Indirect reads are tried with acknowledge latencies of zero, one and three cycles, and the three-cycle case carries a jump-like `start` pulse in the middle of the wait. An indirect jump run back to back with a plain indirect read tells the counter-relative pointer apart from the low-memory one.

// File: rtl/short_ea_unit.sv
module short_ea_unit #(
  parameter int W        = 12,
  parameter int EW       = 6,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  instr,
  input  logic [1:0]    mode,
  input  logic          rel_back,
  input  logic          is_jump,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          result_imm,
  output logic [W-EW-1:0] func_code,
  output logic [W-1:0]  pc
);
  localparam int FW = W - EW;
  localparam logic [1:0] M_IMM = 2'b00, M_DIR = 2'b01, M_IND = 2'b10, M_REL = 2'b11;

  logic [W-1:0] sar, ea_now, ptr, rel_ea, ez, pc_next;
  logic         jmp_q;
  logic         accept, ind;

  assign ez      = {{FW{1'b0}}, instr[EW-1:0]};
  assign accept  = start && !busy;
  assign ind     = (mode == M_IND);
  assign rel_ea  = rel_back ? pc - ez : pc + ez;
  assign ptr     = is_jump ? pc + ez : ez;
  assign pc_next = pc + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (mode)
      M_IMM, M_DIR: ea_now = ez;
      M_REL:        ea_now = rel_ea;
      default:      ea_now = ptr;
    endcase
  end

  assign mem_req  = busy;
  assign mem_addr = sar;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= W'(RESET_PC);
      sar        <= '0;
      result     <= '0;
      result_imm <= 1'b0;
      func_code  <= '0;
      jmp_q      <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        func_code <= instr[W-1:EW];
        sar       <= ea_now;
        jmp_q     <= is_jump;
        if (ind) begin
          busy <= 1'b1;
          pc   <= pc_next;
        end else begin
          result     <= ea_now;
          result_imm <= (mode == M_IMM);
          done       <= 1'b1;
          pc         <= is_jump ? ea_now : pc_next;
        end
      end else if (busy && mem_ack) begin
        result     <= mem_rdata;
        result_imm <= 1'b0;
        done       <= 1'b1;
        busy       <= 1'b0;
        if (jmp_q) pc <= mem_rdata;
      end
    end
  end
endmodule

module short_ea_unit_chk #(
  parameter int W  = 12,
  parameter int EW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [W-1:0]  instr,
  input logic [1:0]    mode,
  input logic          rel_back,
  input logic          is_jump,
  input logic          mem_req,
  input logic [W-1:0]  mem_addr,
  input logic          mem_ack,
  input logic [W-1:0]  mem_rdata,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result,
  input logic          result_imm,
  input logic [W-EW-1:0] func_code,
  input logic [W-1:0]  pc,
  input logic          jmp_q
);
  localparam int FW = W - EW;

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !is_jump) |=> (pc == $past(pc) + W'(1)));

  p_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b00) |=>
      (done && result_imm && result == {{FW{1'b0}}, $past(instr[EW-1:0])}));

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b01) |=>
      (done && !result_imm && mem_addr == {{FW{1'b0}}, $past(instr[EW-1:0])}));

  p_rel_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b11 && !rel_back) |=>
      (done && result == $past(pc) + {{FW{1'b0}}, $past(instr[EW-1:0])}));

  p_rel_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b11 && rel_back) |=>
      (done && result == $past(pc) - {{FW{1'b0}}, $past(instr[EW-1:0])}));

  p_ind_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !busy && result == $past(mem_rdata)));

  p_ind_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && jmp_q) |=> (pc == $past(mem_rdata)));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> ($stable(pc) && $stable(func_code) && !done));

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_req_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind short_ea_unit short_ea_unit_chk #(.W(W), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mode(mode),
  .rel_back(rel_back), .is_jump(is_jump), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
  .busy(busy), .done(done), .result(result), .result_imm(result_imm),
  .func_code(func_code), .pc(pc), .jmp_q(jmp_q)
);

// File: tb/short_ea_unit_bench.sv
`timescale 1ns/1ps
module short_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [1:0]  mode = '0;
  logic        rel_back = 1'b0;
  logic        is_jump = 1'b0;
  logic        mem_req, mem_ack = 1'b0;
  logic [11:0] mem_addr, mem_rdata = '0;
  logic        busy, done, result_imm;
  logic [11:0] result, pc;
  logic [5:0]  func_code;

  always #2 clk = ~clk;

  short_ea_unit u_short_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mode(mode),
    .rel_back(rel_back), .is_jump(is_jump), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .result(result), .result_imm(result_imm),
    .func_code(func_code), .pc(pc)
  );

  typedef struct packed {
    logic [11:0] res;
    logic        imm;
    logic [11:0] pcv;
    logic [5:0]  fc;
    logic [11:0] addr;
    logic        chk_addr;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    tests = 0;
  int    fails = 0;
  int    lat = 0;
  int    wcnt = 0;
  logic [11:0] pcm = '0;

  function automatic logic [11:0] memf(input logic [11:0] a);
    return a * 12'd37 + 12'd3001;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [11:0] act, input logic [11:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // memory model: acknowledge after lat cycles of request
  always @(negedge clk) begin
    if (!mem_req) begin
      wcnt    <= 0;
      mem_ack <= 1'b0;
    end else if (wcnt >= lat) begin
      mem_ack   <= 1'b1;
      mem_rdata <= memf(mem_addr);
    end else begin
      wcnt    <= wcnt + 1;
      mem_ack <= 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", result, '0);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        chk(result == e.res, t, "result", result, e.res);
        chk(result_imm == e.imm, t, "result_imm", 12'(result_imm), 12'(e.imm));
        chk(pc == e.pcv, t, "pc", pc, e.pcv);
        chk(func_code == e.fc, "R2", "func_code", 12'(func_code), 12'(e.fc));
        chk(!mem_req, "R12", "mem_req with done", 12'(mem_req), 12'd0);
        if (e.chk_addr) chk(mem_addr == e.addr, t, "mem_addr", mem_addr, e.addr);
      end
    end
  end

  task automatic issue(input logic [5:0] fc, input logic [5:0] ev,
                       input logic [1:0] md, input bit back, input bit jmp,
                       input int latency, input bit poke, input string tag);
    logic [11:0] p, ez, ea, ptr;
    exp_t x;
    p   = pcm;
    ez  = {6'b0, ev};
    ptr = jmp ? p + ez : ez;
    case (md)
      2'b00, 2'b01: ea = ez;
      2'b11:        ea = back ? p - ez : p + ez;
      default:      ea = memf(ptr);
    endcase
    x.res      = ea;
    x.imm      = (md == 2'b00);
    x.fc       = fc;
    x.chk_addr = (md != 2'b00);
    x.addr     = (md == 2'b10) ? ptr : ea;
    pcm        = jmp ? ea : p + 12'd1;
    x.pcv      = pcm;
    q.push_back(x);
    tq.push_back(tag);
    lat = latency;
    @(negedge clk);
    start = 1'b1; instr = {fc, ev}; mode = md; rel_back = back; is_jump = jmp;
    @(negedge clk);
    start = 1'b0;
    if (md == 2'b10) begin
      chk(busy && mem_req, tag, "mem_req after accept", 12'(mem_req), 12'd1);
      chk(mem_addr == ptr, tag, "pointer address", mem_addr, ptr);
      if (poke) begin
        start = 1'b1; instr = 12'hFFF; mode = 2'b00; is_jump = 1'b1;
        @(negedge clk);
        start = 1'b0; is_jump = 1'b0;
        chk(func_code == fc, "R11", "func_code after ignored start", 12'(func_code), 12'(fc));
        chk(pc == p + 12'd1, "R11", "pc after ignored start", pc, p + 12'd1);
      end
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == 12'd0, "R1", "pc after reset", pc, 12'd0);
    chk(!done && !busy && !mem_req, "R1", "done/busy/mem_req after reset",
        {9'b0, done, busy, mem_req}, 12'd0);

    issue(6'h15, 6'h2A, 2'b00, 0, 0, 0, 0, "R4");   // immediate, pc 0->1 (R3)
    issue(6'h21, 6'h3F, 2'b01, 0, 0, 0, 0, "R5");   // direct, pc 1->2
    issue(6'h30, 6'h0A, 2'b11, 1, 1, 0, 0, "R7");   // 2-10 wraps to FF8, jump (R10)
    issue(6'h02, 6'h3F, 2'b11, 0, 0, 0, 0, "R6");   // FF8+63 wraps to 037
    issue(6'h31, 6'h05, 2'b11, 0, 1, 0, 0, "R10");  // relative forward jump
    issue(6'h32, 6'h10, 2'b01, 0, 1, 0, 0, "R10");  // direct jump to 010
    issue(6'h0C, 6'h07, 2'b10, 0, 0, 0, 0, "R8");   // indirect, zero-latency ack
    issue(6'h0D, 6'h3E, 2'b10, 0, 0, 3, 1, "R8");   // slow ack, ignored start (R11)
    issue(6'h3A, 6'h04, 2'b10, 1, 1, 1, 0, "R9");   // indirect jump from pc+E
    issue(6'h0E, 6'h04, 2'b10, 0, 0, 0, 0, "R8");   // same offset, low memory
    issue(6'h3F, 6'h00, 2'b00, 0, 0, 0, 0, "R3");   // pc step after indirect jump

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11", "pending expectations", 12'(q.size()), 12'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule